// File: doc/BRIEF.md
# Turnaround-Free Pipelined Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a pipelined synchronous SRAM. Reads and writes can follow each other in any order on every enabled clock, with no idle cycles between them. A command is made of the chip selects, the write flag, the address and the byte-lane enables. It is registered on the rising edge. Read data is driven in the cycle that ends at the second enabled edge after the command. Write data is sampled at that same second edge. The data bus therefore carries one beat per command, in command order, whatever the mix of reads and writes.

Write address and lane enables travel down a short pipeline until their data arrives. The memory array is read one stage before that data is committed. A read whose address matches the write currently in its data phase takes the incoming bytes for the enabled lanes and the stored bytes for the rest. A two-bit burst counter lets one loaded address drive up to four accesses, in linear or interleaved order. A clock enable freezes the whole pipeline. Three chip selects and a sleep input turn cycles into deselects and float the output.

Top module: `pipe_sram`

## Requirements
- R1: A read command registered at enabled edge k drives its data on `dout`, with `dout_en` high, after enabled edge k+1, so the data is stable when enabled edge k+2 arrives.
- R2: The write data for a write command registered at enabled edge k is sampled from `din` at enabled edge k+2. Lane i covers bits [9i+8:9i] with the default lane width, and it is written only when `be[i]` is 1.
- R3: Any sequence of reads and writes runs at one command per enabled clock. A read returns the newest data, including a write issued on the clock just before it. That write's enabled lanes come from its data and its other lanes come from the array.
- R4: A write with `be` all zero changes no stored byte. It still takes its pipeline slot, so `dout_en` is low during its data phase.
- R5: While `clk_en` is 0, no stage advances: `dout` and the burst state hold, and `din` is ignored at that edge. A pending write takes its data at the next enabled edge instead.
- R6: A cycle is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Any other combination without `adv` is a deselect: it writes nothing, and `dout_en` is low after the next enabled edge.
- R7: `dout_en` is low throughout the data phase of every write, so the bus never has two drivers.
- R8: While `sleep` is 1, `dout_en` is 0, and any command presented is treated as a deselect. Writes already in flight still complete.
- R9: With `adv`=1, the previous operation continues and the selects, `wr` and `addr` are ignored. The two low address bits are recomputed from the loaded address and the count n=1,2,3,0. With `lin_order`=1 at load time they are (base+n) mod 4; with 0 they are base XOR n. Continuing a deselect stays a deselect.
- R10: A synchronous active-high `rst` clears the pipeline to deselects, drives `dout_en` and `dout` to 0, zeroes the array and leaves the burst state as a deselect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock qualifier; 0 freezes every stage |
| sleep | input | 1 | Low-power request; floats the output and blocks new commands |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| wr | input | 1 | 1 = write command, 0 = read command |
| adv | input | 1 | 1 = continue burst, 0 = load new command |
| lin_order | input | 1 | Burst order captured at load: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address |
| be | input | LANES | Per-lane write enables, active high |
| din | input | LANES*LANE_W | Write data, sampled two enabled edges after its command |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Output-drive indication; 0 means high impedance |

## Verification
The bench uses the default parameters: a 16-word array of two 9-bit lanes. With only sixteen addresses, random traffic lands often on a write still in flight, so forwarding and the per-lane merge are exercised in both lanes. Four aligned blocks of four words let both burst orders wrap inside a block from every starting offset. A reference memory with its own two-stage command pipeline predicts `dout` and `dout_en` on every cycle under random stalls, deselects and sleep.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // Low two address bits of a burst beat: linear adds, interleaved flips.
    function automatic logic [1:0] burst_off(input logic [1:0] lo,
                                             input logic [1:0] n,
                                             input logic       lin);
        return lin ? (lo + n) : (lo ^ n);
    endfunction

endpackage

// File: rtl/pipe_sram_ctl.sv
module pipe_sram_ctl
    import pipe_sram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              sleep,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              wr,
    input  logic              adv,
    input  logic              lin_order,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [LANES-1:0]  s1_be
);

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic              lin_q;
    op_e               last_q;

    op_e               nxt_op;
    logic [ADDR_W-1:0] nxt_addr;
    logic              selected;

    assign selected = !cs1_n && cs2 && !cs3_n;

    always_comb begin
        nxt_addr = addr;
        if (sleep) begin
            nxt_op = OP_IDLE;
        end else if (adv) begin
            nxt_op   = last_q;
            nxt_addr = {base_q[ADDR_W-1:2], burst_off(base_q[1:0], cnt_q, lin_q)};
        end else if (selected) begin
            nxt_op = wr ? OP_WR : OP_RD;
        end else begin
            nxt_op = OP_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_op   <= OP_IDLE;
            s1_addr <= '0;
            s1_be   <= '0;
            base_q  <= '0;
            cnt_q   <= '0;
            lin_q   <= 1'b0;
            last_q  <= OP_IDLE;
        end else if (clk_en) begin
            s1_op   <= nxt_op;
            s1_addr <= nxt_addr;
            s1_be   <= be;
            if (sleep) begin
                last_q <= OP_IDLE;
            end else if (adv) begin
                cnt_q <= cnt_q + 2'd1;
            end else begin
                base_q <= addr;
                cnt_q  <= 2'd1;
                lin_q  <= lin_order;
                last_q <= nxt_op;
            end
        end
    end

endmodule

// File: rtl/pipe_sram_array.sv
module pipe_sram_array #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANES-1:0]  wbe,
    input  logic [DW-1:0]     wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DW-1:0]     rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int d = 0; d < DEPTH; d++) bank[d] <= '0;
            end else if (we && wbe[g]) begin
                bank[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
    end

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
    import pipe_sram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              sleep,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              wr,
    input  logic              adv,
    input  logic              lin_order,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     dout,
    output logic              dout_en
);

    op_e               s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_be;

    op_e               s2_op;
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_be;

    logic [DW-1:0]     arr_rd;
    logic [DW-1:0]     fwd_rd;
    logic              hit;
    logic              oe_q;

    pipe_sram_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .sleep     (sleep),
        .cs1_n     (cs1_n),
        .cs2       (cs2),
        .cs3_n     (cs3_n),
        .wr        (wr),
        .adv       (adv),
        .lin_order (lin_order),
        .addr      (addr),
        .be        (be),
        .s1_op     (s1_op),
        .s1_addr   (s1_addr),
        .s1_be     (s1_be)
    );

    // Stage 2: the write data phase.
    always_ff @(posedge clk) begin
        if (rst) begin
            s2_op   <= OP_IDLE;
            s2_addr <= '0;
            s2_be   <= '0;
        end else if (clk_en) begin
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_be   <= s1_be;
        end
    end

    pipe_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk   (clk),
        .rst   (rst),
        .we    (clk_en && (s2_op == OP_WR)),
        .waddr (s2_addr),
        .wbe   (s2_be),
        .wdata (din),
        .raddr (s1_addr),
        .rdata (arr_rd)
    );

    // A read in stage 1 meets the write committing at this same edge.
    assign hit = (s2_op == OP_WR) && (s2_addr == s1_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign fwd_rd[g*LANE_W +: LANE_W] = (hit && s2_be[g]) ? din[g*LANE_W +: LANE_W]
                                                               : arr_rd[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            oe_q <= 1'b0;
        end else if (clk_en) begin
            oe_q <= (s1_op == OP_RD);
            if (s1_op == OP_RD) dout <= fwd_rd;
        end
    end

    assign dout_en = oe_q && !sleep;

endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk
    import pipe_sram_pkg::*;
#(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          clk_en,
    input logic          sleep,
    input logic [DW-1:0] dout,
    input logic          dout_en,
    input op_e           s1_op,
    input op_e           s2_op
);

    // R1: a read leaving stage 1 drives the bus next cycle unless asleep.
    assert_read_drives_R1: assert property (@(posedge clk) disable iff (rst)
        (clk_en && s1_op == OP_RD) |=> (dout_en || sleep))
        else $error("read did not drive output");

    // R5: a stalled edge leaves output data and pipeline unchanged.
    assert_stall_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(dout) && $stable(s2_op)))
        else $error("state moved during stall");

    // R6: a deselect drains to a floating output.
    assert_deselect_float_R6: assert property (@(posedge clk) disable iff (rst)
        (clk_en && s1_op == OP_IDLE) |=> !dout_en)
        else $error("output driven after deselect");

    // R7: no drive while write data is on the bus.
    assert_no_contention_R7: assert property (@(posedge clk) disable iff (rst)
        (s2_op == OP_WR) |-> !dout_en)
        else $error("output driven in write data phase");

endmodule

bind pipe_sram pipe_sram_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clk_en  (clk_en),
    .sleep   (sleep),
    .dout    (dout),
    .dout_en (dout_en),
    .s1_op   (s1_op),
    .s2_op   (s2_op)
);

// File: tb/tb_pipe_sram.sv
`timescale 1ns/1ps
module tb_pipe_sram;
    localparam int AW = 4, LANES = 2, LW = 9, DW = LANES * LW, DEPTH = 1 << AW;
    localparam logic [2:0] SEL = 3'b010;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, clk_en, sleep, cs1_n, cs2, cs3_n, wr, adv, lin_order;
    logic [AW-1:0] addr;
    logic [LANES-1:0] be;
    logic [DW-1:0] din, dout;
    logic dout_en;

    pipe_sram #(.ADDR_W(AW), .LANES(LANES), .LANE_W(LW)) dut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .sleep(sleep), .cs1_n(cs1_n),
        .cs2(cs2), .cs3_n(cs3_n), .wr(wr), .adv(adv), .lin_order(lin_order),
        .addr(addr), .be(be), .din(din), .dout(dout), .dout_en(dout_en));

    int checks = 0, errors = 0;

    typedef struct packed {
        logic [1:0] op;   // 0 idle, 1 read, 2 write
        logic [AW-1:0] a;
        logic [LANES-1:0] b;
        logic [DW-1:0] d;
    } bcmd_t;

    logic [DW-1:0] ref_mem [DEPTH];
    bcmd_t bp1, bp2;
    logic [AW-1:0] m_base;
    logic [1:0] m_cnt, m_last;
    logic m_lin;
    logic [DW-1:0] exp_dout;
    logic exp_oe;

    // Stimulus table: {ce, sleep, cs[2:0], wr, adv, lin, addr[3:0], be[1:0], data[17:0]}
    localparam logic [31:0] TBL [16] = '{
        {1'b1,1'b0,3'b010,1'b1,1'b0,1'b1,4'h3,2'b11,18'h12345},
        {1'b1,1'b0,3'b010,1'b0,1'b0,1'b1,4'h3,2'b00,18'h00000},
        {1'b1,1'b0,3'b010,1'b1,1'b0,1'b1,4'h3,2'b01,18'h3ffff},
        {1'b1,1'b0,3'b010,1'b0,1'b0,1'b1,4'h3,2'b00,18'h00000},
        {1'b1,1'b0,3'b010,1'b1,1'b0,1'b1,4'h5,2'b11,18'h0aaaa},
        {1'b1,1'b0,3'b010,1'b0,1'b0,1'b0,4'h5,2'b00,18'h00000},
        {1'b1,1'b0,3'b010,1'b0,1'b0,1'b0,4'h3,2'b00,18'h00000},
        {1'b1,1'b0,3'b010,1'b1,1'b0,1'b0,4'h6,2'b10,18'h15555},
        {1'b0,1'b0,3'b010,1'b0,1'b0,1'b0,4'h6,2'b00,18'h00000},
        {1'b1,1'b0,3'b010,1'b0,1'b0,1'b0,4'h6,2'b00,18'h00000},
        {1'b1,1'b0,3'b110,1'b0,1'b0,1'b0,4'h5,2'b00,18'h00000},
        {1'b1,1'b0,3'b010,1'b1,1'b0,1'b0,4'h5,2'b00,18'h00fff},
        {1'b1,1'b0,3'b010,1'b0,1'b0,1'b0,4'h5,2'b00,18'h00000},
        {1'b1,1'b0,3'b010,1'b0,1'b0,1'b1,4'h9,2'b00,18'h00000},
        {1'b1,1'b0,3'b010,1'b1,1'b1,1'b1,4'h0,2'b11,18'h2aaaa},
        {1'b1,1'b0,3'b000,1'b0,1'b0,1'b0,4'h0,2'b00,18'h00000}
    };

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        bp1 = '0; bp2 = '0;
        m_base = '0; m_cnt = '0; m_last = '0; m_lin = 1'b0;
        exp_dout = '0; exp_oe = 1'b0;
    endtask

    task automatic tick(input logic ce, input logic sl, input logic [2:0] cs,
                        input logic w, input logic a_v, input logic lin,
                        input logic [AW-1:0] ad, input logic [LANES-1:0] b,
                        input logic [DW-1:0] wd, input string tag);
        bcmd_t nc;
        logic [1:0] off;
        @(negedge clk);
        clk_en = ce; sleep = sl; {cs1_n, cs2, cs3_n} = cs; wr = w; adv = a_v;
        lin_order = lin; addr = ad; be = b;
        if (bp2.op == 2'd2) din = ce ? bp2.d : ~bp2.d;
        else din = DW'($urandom);
        nc.b = b; nc.d = wd; nc.a = ad;
        if (sl) nc.op = 2'd0;
        else if (a_v) begin
            off = m_lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
            nc.op = m_last;
            nc.a = {m_base[AW-1:2], off};
        end else nc.op = (cs == SEL) ? (w ? 2'd2 : 2'd1) : 2'd0;
        @(posedge clk);
        if (ce) begin
            if (bp2.op == 2'd2)
                for (int l = 0; l < LANES; l++)
                    if (bp2.b[l]) ref_mem[bp2.a][l*LW +: LW] = bp2.d[l*LW +: LW];
            if (bp1.op == 2'd1) begin exp_dout = ref_mem[bp1.a]; exp_oe = 1'b1; end
            else exp_oe = 1'b0;
            bp2 = bp1; bp1 = nc;
            if (sl) m_last = 2'd0;
            else if (a_v) m_cnt = m_cnt + 2'd1;
            else begin m_base = ad; m_cnt = 2'd1; m_lin = lin; m_last = nc.op; end
        end
        #1;
        checks++;
        if (dout_en !== (exp_oe && !sl) || (exp_oe && !sl && dout !== exp_dout)) begin
            errors++;
            $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
                     tag, dout_en, dout, exp_oe && !sl, exp_dout);
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(1, 0, 3'b110, 0, 0, 0, '0, '0, '0, tag);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        tick(1, 0, SEL, 0, 0, 0, a, '0, '0, tag);
    endtask

    task automatic wrt(input logic [AW-1:0] a, input logic [LANES-1:0] b,
                       input logic [DW-1:0] d, input string tag);
        tick(1, 0, SEL, 1, 0, 0, a, b, d, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; clk_en = 1'b0; sleep = 1'b0; {cs1_n, cs2, cs3_n} = 3'b110;
        wr = 0; adv = 0; lin_order = 0; addr = '0; be = '0; din = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        checks++;
        if (dout_en !== 1'b0 || dout !== '0) begin
            errors++;
            $display("FAIL R10 reset state: dout_en=%0b dout=%h expected dout_en=0 dout=0",
                     dout_en, dout);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();
        // R10: the array reads back zero after reset
        rd(4'h5, "R10 array cleared"); idle(2, "R10 array cleared");

        // R1 R2 R3 R4 R5 R6: table walk
        for (int i = 0; i < 16; i++) begin
            v = TBL[i];
            tick(v[31], v[30], v[29:27], v[26], v[25], v[24], v[23:20], v[19:18], v[17:0],
                 "R3 table");
        end
        idle(3, "R3 table drain");

        // R3: read right after a partial write to the same word
        wrt(4'h2, 2'b11, 18'h01234, "R3 setup");
        wrt(4'h2, 2'b10, 18'h3fe00, "R3 fwd partial");
        rd(4'h2, "R3 fwd partial");
        rd(4'h2, "R3 fwd partial");
        idle(2, "R3 fwd partial");

        // R4: no-lane write leaves data and floats its data phase
        wrt(4'h2, 2'b00, 18'h2ffff, "R4 no lanes");
        rd(4'h2, "R4 no lanes"); idle(2, "R4 no lanes");

        // R7: alternating read/write keeps the bus single-driven
        for (int i = 0; i < 6; i++) begin
            rd(AW'(i), "R7 turnaround");
            wrt(AW'(i), 2'b11, DW'(i * 1111), "R7 turnaround");
        end
        idle(2, "R7 turnaround");

        // R5: stalls with junk din; the write lands at the next enabled edge
        wrt(4'h8, 2'b11, 18'h1beef, "R5 stall");
        tick(1, 0, SEL, 0, 0, 0, 4'h8, '0, '0, "R5 stall");
        for (int i = 0; i < 3; i++) tick(0, 0, SEL, 1, 0, 0, 4'h8, 2'b11, 18'h00bad, "R5 stall");
        idle(3, "R5 stall");
        rd(4'h8, "R5 stall"); idle(2, "R5 stall");

        // R6: each select alone deselects
        wrt(4'h1, 2'b11, 18'h11111, "R6 setup");
        tick(1, 0, 3'b110, 1, 0, 0, 4'h1, 2'b11, 18'h22222, "R6 cs1_n");
        tick(1, 0, 3'b000, 1, 0, 0, 4'h1, 2'b11, 18'h33333, "R6 cs2");
        tick(1, 0, 3'b011, 1, 0, 0, 4'h1, 2'b11, 18'h04444, "R6 cs3_n");
        tick(1, 0, 3'b011, 0, 0, 0, 4'h1, 2'b00, '0, "R6 read deselected");
        rd(4'h1, "R6 readback"); idle(2, "R6 readback");

        // R8: sleep blocks commands and floats output
        tick(1, 1, SEL, 1, 0, 0, 4'h1, 2'b11, 18'h05555, "R8 sleep write");
        rd(4'h1, "R8 readback");
        tick(1, 1, SEL, 0, 0, 0, 4'h1, '0, '0, "R8 sleep float");
        tick(1, 0, SEL, 0, 0, 0, 4'h1, '0, '0, "R8 wake");
        idle(2, "R8 wake");

        // R9: linear burst from offset 2, then interleaved from offset 3
        tick(1, 0, SEL, 1, 0, 1, 4'h6, 2'b11, 18'h00a01, "R9 linear");
        for (int i = 0; i < 3; i++)
            tick(1, 0, 3'b110, 0, 1, 0, 4'h0, 2'b11, DW'(18'h00a02 + i), "R9 linear");
        tick(1, 0, SEL, 1, 0, 0, 4'hb, 2'b11, 18'h00b01, "R9 interleaved");
        for (int i = 0; i < 3; i++)
            tick(1, 0, 3'b110, 0, 1, 1, 4'h0, 2'b11, DW'(18'h00b02 + i), "R9 interleaved");
        for (int i = 4; i < 12; i++) rd(AW'(i), "R9 readback");
        tick(1, 0, 3'b110, 1, 0, 0, 4'h4, 2'b11, 18'h0dead, "R9 deselect burst");
        tick(1, 0, SEL, 1, 1, 0, 4'h4, 2'b11, 18'h0dead, "R9 deselect burst");
        rd(4'h5, "R9 deselect burst"); idle(2, "R9 deselect burst");

        // R1 R2 R3 R5 R6 R8 R9: random traffic against the reference
        for (int i = 0; i < 3000; i++) begin
            tick(($urandom % 8) != 0, ($urandom % 40) == 0,
                 (($urandom % 6) == 0) ? 3'($urandom) : SEL,
                 1'($urandom), ($urandom % 4) == 0, 1'($urandom),
                 AW'($urandom), LANES'($urandom), DW'($urandom), "R3 random");
        end
        idle(3, "R3 random drain");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule